// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide NOR flash model. Each write cycle on a synchronous bus carries an address and a data byte. The block matches the multi-write unlock-and-command sequences against these cycles. When a sequence completes, it raises a one-cycle request toward the operation engine: return to array read, byte program, whole-array erase, single-sector erase, or erase suspend. With the program request it latches the target address and data byte. With the sector request it latches the sector number.

The block also has an identifier mode. While this mode is active, the block drives the manufacturer code, the device code, or the protection code of a selected sector onto a read-data port. Which value it drives depends on the low read-address bits.

After a program or erase request, the decoder locks out new commands. It stays locked while the engine reports busy. During a program or a whole-array erase lockout, only the reset byte is honoured. During a sector erase lockout, the suspend byte is honoured as well. Any value that breaks a sequence sends the decoder back to array read mode without a request.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in array read mode: every request output is 0, `idMode` is 0 and `idData` is 00h.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h followed by any fourth write raise `reqProgram` for exactly one cycle, in the cycle after the fourth write is sampled. In that same cycle, `progAddr` and `progData` hold that write's address and data. Both keep their values until the next program request.
- R3: Only address bits 10..0 take part in matching the unlock addresses 555h and 2AAh. Bits 18..11 of those writes are ignored.
- R4: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `reqChipErase` for one cycle.
- R5: The same five-write prefix followed by 30h at any address raises `reqSectorErase` for one cycle. `sectorSel` then holds address bits 18..16 of that sixth write.
- R6: A write whose address or data does not fit the next step of a sequence returns the decoder to read mode with no request. A later sequence must restart from its first write.
- R7: Outside a lockout, writing F0h (other than as the program data write) raises `reqRead` for one cycle and returns the decoder to read mode, which also leaves identifier mode.
- R8: The writes AAh@555h, 55h@2AAh, ID_CMD@555h set `idMode`. In that mode `idData` depends on the read offset bits {A1,A0}: 00 gives C2h, 01 gives A4h, and 1x gives 01h if `protMask` bit `idSector` is set and 00h otherwise. Outside identifier mode `idData` is 00h.
- R9: After a program or whole-array erase request, all writes except F0h are ignored. The lockout ends on the first cycle, at least two cycles after the request, in which `busy` is low. An F0h write during the lockout raises `reqRead` and ends it at once.
- R10: During a sector erase lockout, a B0h write raises `reqSuspend` for one cycle and returns the decoder to read mode. F0h acts as in R9, and all other writes are ignored. B0h has no effect in any other lockout.
- R11: The identifier command byte is the parameter ID_CMD, which defaults to 90h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write cycle strobe, one sample per cycle |
| wrAddr | input | 19 | Write address |
| wrData | input | 8 | Write data byte |
| busy | input | 1 | Operation engine busy |
| protMask | input | 8 | Per-sector protection flags |
| idSector | input | 3 | Read address bits 18..16 in identifier mode |
| idOffset | input | 2 | Read address bits 1..0 in identifier mode |
| reqRead | output | 1 | Return-to-read request pulse |
| reqProgram | output | 1 | Byte program request pulse |
| reqChipErase | output | 1 | Whole-array erase request pulse |
| reqSectorErase | output | 1 | Sector erase request pulse |
| reqSuspend | output | 1 | Erase suspend request pulse |
| progAddr | output | 19 | Latched program address |
| progData | output | 8 | Latched program data |
| sectorSel | output | 3 | Latched sector number |
| idMode | output | 1 | Identifier mode active |
| idData | output | 8 | Identifier read data |

## Verification
The bench drives complete program, whole-array erase, sector erase and identifier sequences. In some of them the unlock addresses carry set upper bits, which checks that only the low eleven bits are decoded. Broken sequences cover a wrong data byte, a wrong low address bit and a valid byte written out of order. Each broken sequence is followed by the tail of a real command, which shows whether the partial progress was discarded. Writes that arrive during each kind of lockout show which bytes each lockout honours, and a busy release shows when the decoder starts accepting commands again.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNLK1,
    ST_UNLK2,
    ST_PROG_ARM,
    ST_ERS_SETUP,
    ST_ERS_UNLK1,
    ST_ERS_UNLK2,
    ST_IDENT,
    ST_LOCK_PROG,
    ST_LOCK_CHIP,
    ST_LOCK_SECT
  } cmdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchProg;
    logic latchSector;
  } dpStrobe_t;

  // decoded view of the current write, datapath to control
  typedef struct packed {
    logic atKeyA;    // low bits equal 555h
    logic atKeyB;    // low bits equal 2AAh
    logic isAA;
    logic is55;
    logic isPgm;
    logic isErsSetup;
    logic isChip;
    logic isSect;
    logic isSusp;
    logic isReset;
    logic isIdent;
  } wrMatch_t;

endpackage

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CMP_W     = 11,
  parameter int SECT_BITS = 3,
  parameter logic [DATA_W-1:0] ID_CMD   = 8'h90,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hC2,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'hA4,
  localparam int NUM_SECT = 1 << SECT_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  dpStrobe_t            strobe,
  input  logic                 idMode,
  input  logic [NUM_SECT-1:0]  protMask,
  input  logic [SECT_BITS-1:0] idSector,
  input  logic [1:0]           idOffset,
  output wrMatch_t             match,
  output logic [ADDR_W-1:0]    progAddr,
  output logic [DATA_W-1:0]    progData,
  output logic [SECT_BITS-1:0] sectorSel,
  output logic [DATA_W-1:0]    idData
);

  localparam logic [CMP_W-1:0]  KEY_A      = CMP_W'('h555);
  localparam logic [CMP_W-1:0]  KEY_B      = CMP_W'('h2AA);
  localparam logic [DATA_W-1:0] B_AA       = DATA_W'('hAA);
  localparam logic [DATA_W-1:0] B_55       = DATA_W'('h55);
  localparam logic [DATA_W-1:0] B_PGM      = DATA_W'('hA0);
  localparam logic [DATA_W-1:0] B_ERS      = DATA_W'('h80);
  localparam logic [DATA_W-1:0] B_CHIP     = DATA_W'('h10);
  localparam logic [DATA_W-1:0] B_SECT     = DATA_W'('h30);
  localparam logic [DATA_W-1:0] B_SUSP     = DATA_W'('hB0);
  localparam logic [DATA_W-1:0] B_RESET    = DATA_W'('hF0);
  localparam int                SECT_LSB   = ADDR_W - SECT_BITS;

  logic [CMP_W-1:0] lowAddr;
  assign lowAddr = wrAddr[CMP_W-1:0];

  always_comb begin
    match.atKeyA     = (lowAddr == KEY_A);
    match.atKeyB     = (lowAddr == KEY_B);
    match.isAA       = (wrData == B_AA);
    match.is55       = (wrData == B_55);
    match.isPgm      = (wrData == B_PGM);
    match.isErsSetup = (wrData == B_ERS);
    match.isChip     = (wrData == B_CHIP);
    match.isSect     = (wrData == B_SECT);
    match.isSusp     = (wrData == B_SUSP);
    match.isReset    = (wrData == B_RESET);
    match.isIdent    = (wrData == ID_CMD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progAddr <= '0;
      progData <= '0;
    end else if (strobe.latchProg) begin
      progAddr <= wrAddr;
      progData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectorSel <= '0;
    end else if (strobe.latchSector) begin
      sectorSel <= wrAddr[SECT_LSB +: SECT_BITS];
    end
  end

  logic [NUM_SECT-1:0] protBits;
  logic                protHit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SECT; gi++) begin : g_prot
      assign protBits[gi] = protMask[gi] && (idSector == SECT_BITS'(gi));
    end
  endgenerate
  assign protHit = |protBits;

  always_comb begin
    if (!idMode) begin
      idData = '0;
    end else if (idOffset[1]) begin
      idData = {{(DATA_W-1){1'b0}}, protHit};
    end else if (idOffset[0]) begin
      idData = DEV_CODE;
    end else begin
      idData = MFR_CODE;
    end
  end

endmodule

// File: rtl/flash_cmd_control.sv
module flash_cmd_control
  import flash_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      busy,
  input  wrMatch_t  match,
  output dpStrobe_t strobe,
  output logic      idMode,
  output logic      reqRead,
  output logic      reqProgram,
  output logic      reqChipErase,
  output logic      reqSectorErase,
  output logic      reqSuspend
);

  cmdState_t state, stateNxt;
  logic      lockFirst, lockFirstNxt;
  logic      rdNxt, pgNxt, chNxt, seNxt, suNxt;
  logic      inLock;

  assign inLock = (state == ST_LOCK_PROG) || (state == ST_LOCK_CHIP) ||
                  (state == ST_LOCK_SECT);

  always_comb begin
    stateNxt     = state;
    lockFirstNxt = 1'b0;
    strobe       = '0;
    rdNxt        = 1'b0;
    pgNxt        = 1'b0;
    chNxt        = 1'b0;
    seNxt        = 1'b0;
    suNxt        = 1'b0;

    if (inLock) begin
      if (wrEn && match.isReset) begin
        rdNxt    = 1'b1;
        stateNxt = ST_IDLE;
      end else if (wrEn && match.isSusp && state == ST_LOCK_SECT) begin
        suNxt    = 1'b1;
        stateNxt = ST_IDLE;
      end else if (!lockFirst && !busy) begin
        stateNxt = ST_IDLE;
      end
    end else if (wrEn) begin
      if (state == ST_PROG_ARM) begin
        pgNxt            = 1'b1;
        strobe.latchProg = 1'b1;
        lockFirstNxt     = 1'b1;
        stateNxt         = ST_LOCK_PROG;
      end else if (match.isReset) begin
        rdNxt    = 1'b1;
        stateNxt = ST_IDLE;
      end else begin
        stateNxt = ST_IDLE;
        unique case (state)
          ST_IDLE, ST_IDENT: begin
            if (match.isAA && match.atKeyA) stateNxt = ST_UNLK1;
          end
          ST_UNLK1: begin
            if (match.is55 && match.atKeyB) stateNxt = ST_UNLK2;
          end
          ST_UNLK2: begin
            if (match.atKeyA) begin
              if (match.isPgm)           stateNxt = ST_PROG_ARM;
              else if (match.isErsSetup) stateNxt = ST_ERS_SETUP;
              else if (match.isIdent)    stateNxt = ST_IDENT;
            end
          end
          ST_ERS_SETUP: begin
            if (match.isAA && match.atKeyA) stateNxt = ST_ERS_UNLK1;
          end
          ST_ERS_UNLK1: begin
            if (match.is55 && match.atKeyB) stateNxt = ST_ERS_UNLK2;
          end
          ST_ERS_UNLK2: begin
            if (match.isChip && match.atKeyA) begin
              chNxt        = 1'b1;
              lockFirstNxt = 1'b1;
              stateNxt     = ST_LOCK_CHIP;
            end else if (match.isSect) begin
              seNxt              = 1'b1;
              strobe.latchSector = 1'b1;
              lockFirstNxt       = 1'b1;
              stateNxt           = ST_LOCK_SECT;
            end
          end
          default: stateNxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      lockFirst      <= 1'b0;
      reqRead        <= 1'b0;
      reqProgram     <= 1'b0;
      reqChipErase   <= 1'b0;
      reqSectorErase <= 1'b0;
      reqSuspend     <= 1'b0;
    end else begin
      state          <= stateNxt;
      lockFirst      <= lockFirstNxt;
      reqRead        <= rdNxt;
      reqProgram     <= pgNxt;
      reqChipErase   <= chNxt;
      reqSectorErase <= seNxt;
      reqSuspend     <= suNxt;
    end
  end

  assign idMode = (state == ST_IDENT);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CMP_W     = 11,
  parameter int SECT_BITS = 3,
  parameter logic [DATA_W-1:0] ID_CMD   = 8'h90,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hC2,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'hA4,
  localparam int NUM_SECT = 1 << SECT_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 busy,
  input  logic [NUM_SECT-1:0]  protMask,
  input  logic [SECT_BITS-1:0] idSector,
  input  logic [1:0]           idOffset,
  output logic                 reqRead,
  output logic                 reqProgram,
  output logic                 reqChipErase,
  output logic                 reqSectorErase,
  output logic                 reqSuspend,
  output logic [ADDR_W-1:0]    progAddr,
  output logic [DATA_W-1:0]    progData,
  output logic [SECT_BITS-1:0] sectorSel,
  output logic                 idMode,
  output logic [DATA_W-1:0]    idData
);

  dpStrobe_t strobe;
  wrMatch_t  match;

  flash_cmd_control u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .wrEn           (wrEn),
    .busy           (busy),
    .match          (match),
    .strobe         (strobe),
    .idMode         (idMode),
    .reqRead        (reqRead),
    .reqProgram     (reqProgram),
    .reqChipErase   (reqChipErase),
    .reqSectorErase (reqSectorErase),
    .reqSuspend     (reqSuspend)
  );

  flash_cmd_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CMP_W     (CMP_W),
    .SECT_BITS (SECT_BITS),
    .ID_CMD    (ID_CMD),
    .MFR_CODE  (MFR_CODE),
    .DEV_CODE  (DEV_CODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .idMode    (idMode),
    .protMask  (protMask),
    .idSector  (idSector),
    .idOffset  (idOffset),
    .match     (match),
    .progAddr  (progAddr),
    .progData  (progData),
    .sectorSel (sectorSel),
    .idData    (idData)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              reqRead,
  input logic              reqProgram,
  input logic              reqChipErase,
  input logic              reqSectorErase,
  input logic              reqSuspend,
  input logic [ADDR_W-1:0] progAddr,
  input logic [DATA_W-1:0] progData,
  input logic              idMode,
  input logic [DATA_W-1:0] idData
);

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqRead, reqProgram, reqChipErase, reqSectorErase, reqSuspend})); // R6

  AST_PROG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    reqProgram |-> $past(wrEn) && progAddr == $past(wrAddr) && progData == $past(wrData)); // R2

  AST_PROG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !reqProgram |-> $stable(progAddr) && $stable(progData)); // R2

  AST_CHIP_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    reqChipErase |-> $past(wrEn) && $past(wrData) == 8'h10 && $past(wrAddr[10:0]) == 11'h555); // R4

  AST_SECT_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    reqSectorErase |-> $past(wrEn) && $past(wrData) == 8'h30); // R5

  AST_READ_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    reqRead |-> $past(wrEn) && $past(wrData) == 8'hF0); // R7

  AST_SUSP_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    reqSuspend |-> $past(wrEn) && $past(wrData) == 8'hB0); // R10

  AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !idMode |-> idData == '0); // R8

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqProgram |=> !reqProgram); // R9

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .wrEn           (wrEn),
  .wrAddr         (wrAddr),
  .wrData         (wrData),
  .reqRead        (reqRead),
  .reqProgram     (reqProgram),
  .reqChipErase   (reqChipErase),
  .reqSectorErase (reqSectorErase),
  .reqSuspend     (reqSuspend),
  .progAddr       (progAddr),
  .progData       (progData),
  .idMode         (idMode),
  .idData         (idData)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;

  localparam logic [4:0] NONE = 5'b00000;
  localparam logic [4:0] RD   = 5'b10000;
  localparam logic [4:0] PG   = 5'b01000;
  localparam logic [4:0] CH   = 5'b00100;
  localparam logic [4:0] SE   = 5'b00010;
  localparam logic [4:0] SU   = 5'b00001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [18:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        busy = 1'b0;
  logic [7:0]  protMask = 8'b0010_0001;
  logic [2:0]  idSector = '0;
  logic [1:0]  idOffset = '0;
  logic        reqRead, reqProgram, reqChipErase, reqSectorErase, reqSuspend;
  logic [18:0] progAddr;
  logic [7:0]  progData;
  logic [2:0]  sectorSel;
  logic        idMode;
  logic [7:0]  idData;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk            (clk),
    .rstN           (rstN),
    .wrEn           (wrEn),
    .wrAddr         (wrAddr),
    .wrData         (wrData),
    .busy           (busy),
    .protMask       (protMask),
    .idSector       (idSector),
    .idOffset       (idOffset),
    .reqRead        (reqRead),
    .reqProgram     (reqProgram),
    .reqChipErase   (reqChipErase),
    .reqSectorErase (reqSectorErase),
    .reqSuspend     (reqSuspend),
    .progAddr       (progAddr),
    .progData       (progData),
    .sectorSel      (sectorSel),
    .idMode         (idMode),
    .idData         (idData)
  );

  function automatic logic [4:0] reqVec();
    return {reqRead, reqProgram, reqChipErase, reqSectorErase, reqSuspend};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one write cycle; returns at the negedge after the sampling edge
  task automatic wr(input logic [18:0] a, input logic [7:0] d,
                    input logic [4:0] expReq, input string tag);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    chk(tag, 32'(reqVec()), 32'(expReq));
  endtask

  task automatic unlock(input logic [18:0] hi, input string tag);
    wr(hi | 19'h555, 8'hAA, NONE, tag);
    wr(hi | 19'h2AA, 8'h55, NONE, tag);
  endtask

  task automatic test_reset();
    chk("R1 req", 32'(reqVec()), 32'(NONE));
    chk("R1 idMode", 32'(idMode), 0);
    chk("R1 idData", 32'(idData), 0);
  endtask

  task automatic test_program();
    unlock(19'h0, "R2 unlock");
    wr(19'h555, 8'hA0, NONE, "R2 cmd");
    wr(19'h4_1234, 8'h5A, PG, "R2 req");
    chk("R2 addr", 32'(progAddr), 32'h4_1234);
    chk("R2 data", 32'(progData), 32'h5A);
    idle(1);
    chk("R2 pulse", 32'(reqVec()), 32'(NONE));
    idle(3);
    // R3: upper bits set on every unlock write
    unlock(19'h7_F800, "R3 unlock");
    wr(19'h3_8D55, 8'hA0, NONE, "R3 cmd");
    wr(19'h0_0007, 8'h11, PG, "R3 req");
    chk("R2 hold addr", 32'(progAddr), 32'h7);
    idle(4);
  endtask

  task automatic test_chip();
    unlock(19'h0, "R4 u1");
    wr(19'h555, 8'h80, NONE, "R4 setup");
    unlock(19'h1_0000, "R4 u2");
    wr(19'h2_0555, 8'h10, CH, "R4 req");
    idle(4);
  endtask

  task automatic test_sector();
    unlock(19'h0, "R5 u1");
    wr(19'h555, 8'h80, NONE, "R5 setup");
    unlock(19'h0, "R5 u2");
    wr(19'h5_0123, 8'h30, SE, "R5 req");
    chk("R5 sector", 32'(sectorSel), 5);
    idle(4);
  endtask

  task automatic test_abort();
    // wrong data byte at step two, then program tail
    wr(19'h555, 8'hAA, NONE, "R6 a");
    wr(19'h2AA, 8'h56, NONE, "R6 badData");
    wr(19'h555, 8'hA0, NONE, "R6 tail");
    wr(19'h100, 8'h22, NONE, "R6 noProg1");
    // wrong low address bit
    wr(19'h555, 8'hAA, NONE, "R6 b");
    wr(19'h2AB, 8'h55, NONE, "R6 badAddr");
    wr(19'h555, 8'hA0, NONE, "R6 tail2");
    wr(19'h100, 8'h22, NONE, "R6 noProg2");
    // R3 negative: address bit 0 of the first unlock wrong
    wr(19'h7_F554, 8'hAA, NONE, "R3 neg");
    wr(19'h2AA, 8'h55, NONE, "R3 neg2");
    wr(19'h555, 8'hA0, NONE, "R3 neg3");
    wr(19'h100, 8'h22, NONE, "R3 noProg");
    // valid byte out of order: 80h before the unlock pair
    wr(19'h555, 8'h80, NONE, "R6 order");
    unlock(19'h0, "R6 order u");
    wr(19'h555, 8'h10, NONE, "R6 noChip");
    // full sequence recovers
    unlock(19'h0, "R6 rec");
    wr(19'h555, 8'hA0, NONE, "R6 rec cmd");
    wr(19'h200, 8'h33, PG, "R6 recovered");
    idle(4);
  endtask

  task automatic test_reset_cmd();
    wr(19'h555, 8'hAA, NONE, "R7 a");
    wr(19'h123, 8'hF0, RD, "R7 req");
    wr(19'h2AA, 8'h55, NONE, "R7 restart");
    wr(19'h555, 8'hA0, NONE, "R7 restart2");
    wr(19'h300, 8'h44, NONE, "R7 noProg");
  endtask

  task automatic test_ident();
    unlock(19'h0, "R8 u");
    wr(19'h555, 8'h90, NONE, "R11 cmd");
    chk("R11 idMode", 32'(idMode), 1);
    idSector = 3'd4; idOffset = 2'b00; #1;
    chk("R8 mfr", 32'(idData), 32'hC2);
    idOffset = 2'b01; #1;
    chk("R8 dev", 32'(idData), 32'hA4);
    idOffset = 2'b10; idSector = 3'd5; #1;
    chk("R8 prot", 32'(idData), 32'h01);
    idSector = 3'd2; #1;
    chk("R8 unprot", 32'(idData), 32'h00);
    idSector = 3'd0; idOffset = 2'b11; #1;
    chk("R8 prot0", 32'(idData), 32'h01);
    wr(19'h0, 8'hF0, RD, "R7 exitId");
    chk("R7 idMode", 32'(idMode), 0);
    chk("R8 quiet", 32'(idData), 0);
    idOffset = 2'b00;
  endtask

  task automatic test_prog_lock();
    unlock(19'h0, "R9 u");
    wr(19'h555, 8'hA0, NONE, "R9 cmd");
    wr(19'h0_0AAA, 8'h77, PG, "R9 req");
    busy = 1'b1;
    unlock(19'h0, "R9 ignU");
    wr(19'h555, 8'h80, NONE, "R9 ign80");
    wr(19'h555, 8'hB0, NONE, "R9 ignB0");
    chk("R9 addrKept", 32'(progAddr), 32'h0AAA);
    busy = 1'b0;
    idle(3);
    // partial progress during lock must not survive
    wr(19'h555, 8'hA0, NONE, "R9 afterA0");
    wr(19'h400, 8'h12, NONE, "R9 noProg");
    // chip lock: B0 ignored, F0 aborts
    unlock(19'h0, "R9 cu");
    wr(19'h555, 8'h80, NONE, "R9 c80");
    unlock(19'h0, "R9 cu2");
    wr(19'h555, 8'h10, CH, "R9 chip");
    busy = 1'b1;
    wr(19'h0, 8'hB0, NONE, "R10 chipB0");
    wr(19'h0, 8'hF0, RD, "R9 abort");
    unlock(19'h0, "R9 post");
    wr(19'h555, 8'hA0, NONE, "R9 postcmd");
    wr(19'h500, 8'h66, PG, "R9 postProg");
    busy = 1'b0;
    idle(4);
  endtask

  task automatic test_sect_lock();
    unlock(19'h0, "R10 u");
    wr(19'h555, 8'h80, NONE, "R10 s");
    unlock(19'h0, "R10 u2");
    wr(19'h3_0000, 8'h30, SE, "R10 req");
    chk("R10 sector", 32'(sectorSel), 3);
    busy = 1'b1;
    wr(19'h555, 8'hAA, NONE, "R10 ign");
    wr(19'h3_0000, 8'h30, NONE, "R10 ign30");
    wr(19'h0, 8'hB0, SU, "R10 susp");
    unlock(19'h0, "R10 after");
    wr(19'h555, 8'hA0, NONE, "R10 pcmd");
    wr(19'h600, 8'h99, PG, "R10 prog");
    busy = 1'b0;
    idle(4);
  endtask

  initial begin
    idle(3);
    test_reset();
    rstN = 1'b1;
    idle(2);
    test_reset();
    test_program();
    test_chip();
    test_sector();
    test_abort();
    test_reset_cmd();
    test_ident();
    test_prog_lock();
    test_sect_lock();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule